// File: doc/BRIEF.md
# Serial Printer Handshake Monitor

This block controls the flow of bytes to a serial printer. It sits beside the byte transmitter and leaves the serialising of data to that transmitter. Before each byte, the transmitter asks the block for permission. The block grants the request only while the printer signals that it can accept data. When the printer withdraws its ready line, the block still lets a small, bounded number of bytes go out, because a byte may already be committed when the line falls. While a byte is on the wire, the block watches two status lines from the printer: an "equipment ok" line and a paper status line. A bad state on either one latches a fault and a cause code.

Three static configuration bits shape the behaviour. One bit enables the equipment-ok check. One bit forces the link-active output high at all times. Without that bit, link-active is high only while a byte is in flight. One bit selects which level of the paper line counts as an error. A unit-alive output rises once the block leaves reset. Every printer-side input passes through a two-flop synchroniser before the block uses it.

Top module: `prn_handshake_mon`

## Requirements
- R1: `tx_permit_o` is high only when all of the following hold: the unit is alive, no byte is in flight, no fault is latched, and either the synchronised ready line is high or the allowance is non-zero. A byte is granted when `send_req_i` is high in a cycle where `tx_permit_o` is high.
- R2: After the synchronised ready line falls, at most OVERRUN_BYTES (default 2) further bytes are granted. After that, `tx_permit_o` stays low.
- R3: The allowance reloads to OVERRUN_BYTES in every cycle in which the synchronised ready line is high, so each new low phase of ready grants the full allowance again. Out of reset, the allowance is zero.
- R4: A granted byte stays in flight until `byte_sent_i` is pulsed. If `cfg_ok_check_i` is 1 and the ok line is low while a byte is in flight, a fault with cause 2'b01 is latched. If `cfg_ok_check_i` is 0, the ok line is ignored.
- R5: If the paper line equals `cfg_paper_high_err_i` while a byte is in flight, a fault with cause 2'b10 is latched. So with the bit at 1, a high paper line is an error, and with the bit at 0, a low paper line is an error.
- R6: Status lines raise no fault while no byte is in flight. When both conditions occur in the same cycle, cause 2'b01 wins.
- R7: A fault holds its cause and blocks `tx_permit_o` until `err_clr_i` is pulsed. A clear takes priority over a new fault in the same cycle. With no fault, the cause reads 2'b00.
- R8: `link_active_o` is 1 whenever the unit is alive if `cfg_link_always_i` is 1. Otherwise it is 1 only while a byte is in flight.
- R9: `unit_alive_o` is 0 while `rst_n` is low. It goes to 1 on the third rising edge after `rst_n` is released, and stays at 1.
- R10: A change on a printer-side input becomes visible after two rising edges. A fault appears on `fault_o` at the third rising edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_req_i | input | 1 | Transmitter asks to start a byte |
| byte_sent_i | input | 1 | Pulse: the byte in flight is finished |
| periph_ready_i | input | 1 | Printer can accept data |
| periph_ok_i | input | 1 | Printer equipment ok |
| paper_stat_i | input | 1 | Printer paper status line |
| cfg_ok_check_i | input | 1 | Enable the equipment-ok check |
| cfg_link_always_i | input | 1 | Hold link-active high while alive |
| cfg_paper_high_err_i | input | 1 | Paper line level that means error |
| err_clr_i | input | 1 | Clear the latched fault |
| tx_permit_o | output | 1 | A byte may be started |
| link_active_o | output | 1 | Link-active indication to printer |
| fault_o | output | 1 | Fault latched |
| fault_cause_o | output | 2 | 00 none, 01 equipment, 10 paper |
| unit_alive_o | output | 1 | Unit is out of reset |

## Verification
A byte request or completion changes `tx_permit_o` and `link_active_o` one edge later. A printer-side input changes `tx_permit_o` two edges later and `fault_o` three edges later. A clear removes the fault one edge later, and `unit_alive_o` rises three edges after reset release. The bench drives and samples on falling edges. For latency checks, it samples on both sides of the due edge: after two edges to confirm the fault is still absent, then after three to confirm it is present. All other checks wait three or more falling edges after a printer-side input change before sampling.

// File: rtl/prn_hs_pkg.sv
package prn_hs_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_EQUIP = 2'b01,
    CAUSE_PAPER = 2'b10
  } fault_cause_e;
endpackage

// File: rtl/prn_hs_sync.sv
module prn_hs_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/prn_hs_allowance.sv
module prn_hs_allowance #(
  parameter int unsigned OVERRUN_BYTES = 2,
  localparam int unsigned CW = $clog2(OVERRUN_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready_s,
  input  logic          grant,
  output logic [CW-1:0] credit_o
);
  logic [CW-1:0] credit_q, credit_d;
  logic          credit_en;

  always_comb begin
    credit_en = 1'b0;
    credit_d  = credit_q;
    if (ready_s) begin
      credit_en = 1'b1;
      credit_d  = CW'(OVERRUN_BYTES);
    end else if (grant && credit_q != '0) begin
      credit_en = 1'b1;
      credit_d  = credit_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credit_q <= '0;
    else if (credit_en) credit_q <= credit_d;
  end

  assign credit_o = credit_q;
endmodule

// File: rtl/prn_hs_fault.sv
module prn_hs_fault
  import prn_hs_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         ok_s,
  input  logic         paper_s,
  input  logic         cfg_ok_check,
  input  logic         cfg_paper_high_err,
  input  logic         clr,
  output logic         fault_o,
  output fault_cause_e cause_o
);
  fault_cause_e cause_q, cause_d;
  logic         cause_en;
  logic         equip_bad, paper_bad;

  always_comb begin
    equip_bad = busy & cfg_ok_check & ~ok_s;
    paper_bad = busy & (paper_s == cfg_paper_high_err);
    cause_en  = 1'b0;
    cause_d   = cause_q;
    if (clr) begin
      cause_en = 1'b1;
      cause_d  = CAUSE_NONE;
    end else if (cause_q == CAUSE_NONE) begin
      if (equip_bad) begin
        cause_en = 1'b1;
        cause_d  = CAUSE_EQUIP;
      end else if (paper_bad) begin
        cause_en = 1'b1;
        cause_d  = CAUSE_PAPER;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= CAUSE_NONE;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;
  assign fault_o = (cause_q != CAUSE_NONE);
endmodule

// File: rtl/prn_handshake_mon.sv
module prn_handshake_mon
  import prn_hs_pkg::*;
#(
  parameter int unsigned OVERRUN_BYTES = 2,
  parameter int unsigned SYNC_STAGES   = 2,
  localparam int unsigned CW = $clog2(OVERRUN_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_req_i,
  input  logic       byte_sent_i,
  input  logic       periph_ready_i,
  input  logic       periph_ok_i,
  input  logic       paper_stat_i,
  input  logic       cfg_ok_check_i,
  input  logic       cfg_link_always_i,
  input  logic       cfg_paper_high_err_i,
  input  logic       err_clr_i,
  output logic       tx_permit_o,
  output logic       link_active_o,
  output logic       fault_o,
  output logic [1:0] fault_cause_o,
  output logic       unit_alive_o
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // printer-side inputs
  logic [2:0] periph_s;
  logic       ready_s, ok_s, paper_s;

  prn_hs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_sn),
    .async_i ({paper_stat_i, periph_ok_i, periph_ready_i}),
    .sync_o  (periph_s)
  );
  assign {paper_s, ok_s, ready_s} = periph_s;

  // alive flag
  logic alive_q, alive_en;
  assign alive_en = ~alive_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) alive_q <= 1'b0;
    else if (alive_en) alive_q <= 1'b1;
  end

  // byte in flight
  logic busy_q, busy_d, busy_en, grant;
  logic [CW-1:0] credit;
  fault_cause_e  cause;
  logic          fault;

  assign tx_permit_o = alive_q & ~busy_q & ~fault & (ready_s | (credit != '0));
  assign grant       = send_req_i & tx_permit_o;

  always_comb begin
    busy_en = grant | (busy_q & byte_sent_i);
    busy_d  = grant;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  prn_hs_allowance #(.OVERRUN_BYTES(OVERRUN_BYTES)) i_allow (
    .clk      (clk),
    .rst_n    (rst_sn),
    .ready_s  (ready_s),
    .grant    (grant),
    .credit_o (credit)
  );

  prn_hs_fault i_fault (
    .clk                (clk),
    .rst_n              (rst_sn),
    .busy               (busy_q),
    .ok_s               (ok_s),
    .paper_s            (paper_s),
    .cfg_ok_check       (cfg_ok_check_i),
    .cfg_paper_high_err (cfg_paper_high_err_i),
    .clr                (err_clr_i),
    .fault_o            (fault),
    .cause_o            (cause)
  );

  assign fault_o       = fault;
  assign fault_cause_o = cause;
  assign link_active_o = alive_q & (cfg_link_always_i | busy_q);
  assign unit_alive_o  = alive_q;
endmodule

// File: rtl/prn_hs_checker.sv
module prn_hs_checker #(
  parameter int unsigned OVERRUN_BYTES = 2,
  localparam int unsigned CW = $clog2(OVERRUN_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          tx_permit_o,
  input logic          fault_o,
  input logic [1:0]    fault_cause_o,
  input logic          err_clr_i,
  input logic          unit_alive_o,
  input logic          ready_s,
  input logic [CW-1:0] credit
);
  // R7
  a_r7_fault_blocks: assert property (@(posedge clk) disable iff (!rst_sn)
    fault_o |-> !tx_permit_o);
  // R7
  a_r7_fault_holds: assert property (@(posedge clk) disable iff (!rst_sn)
    (fault_o && !err_clr_i) |=> (fault_o && $stable(fault_cause_o)));
  // R7
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_sn)
    err_clr_i |=> !fault_o);
  // R4 / R5
  a_r5_cause_single: assert property (@(posedge clk) disable iff (!rst_sn)
    fault_o |-> ($countones(fault_cause_o) == 1));
  // R2
  a_r2_credit_bound: assert property (@(posedge clk) disable iff (!rst_sn)
    credit <= CW'(OVERRUN_BYTES));
  // R2
  a_r2_spent_blocks: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ready_s && credit == '0) |-> !tx_permit_o);
  // R9
  a_r9_alive_sticks: assert property (@(posedge clk) disable iff (!rst_sn)
    unit_alive_o |=> unit_alive_o);
endmodule

bind prn_handshake_mon prn_hs_checker #(.OVERRUN_BYTES(OVERRUN_BYTES)) i_chk (
  .clk           (clk),
  .rst_sn        (rst_sn),
  .tx_permit_o   (tx_permit_o),
  .fault_o       (fault_o),
  .fault_cause_o (fault_cause_o),
  .err_clr_i     (err_clr_i),
  .unit_alive_o  (unit_alive_o),
  .ready_s       (ready_s),
  .credit        (credit)
);

// File: tb/test_prn_handshake_mon.sv
module test_prn_handshake_mon;
  logic clk = 1'b0;
  logic rst_n, send_req, byte_sent, ready, ok, paper;
  logic cfg_ok_chk, cfg_link_all, cfg_pap_hi, clr;
  logic permit, link, fault, alive;
  logic [1:0] cause;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prn_handshake_mon i_prn_handshake_mon (
    .clk(clk), .rst_n(rst_n), .send_req_i(send_req), .byte_sent_i(byte_sent),
    .periph_ready_i(ready), .periph_ok_i(ok), .paper_stat_i(paper),
    .cfg_ok_check_i(cfg_ok_chk), .cfg_link_always_i(cfg_link_all),
    .cfg_paper_high_err_i(cfg_pap_hi), .err_clr_i(clr),
    .tx_permit_o(permit), .link_active_o(link), .fault_o(fault),
    .fault_cause_o(cause), .unit_alive_o(alive)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_byte(output bit granted);
    granted = permit;
    send_req = 1'b1;
    @(negedge clk);
    send_req = 1'b0;
  endtask

  task automatic end_byte();
    byte_sent = 1'b1;
    @(negedge clk);
    byte_sent = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; send_req = 0; byte_sent = 0; ready = 1; ok = 1; paper = 0;
    cfg_ok_chk = 1; cfg_link_all = 0; cfg_pap_hi = 1; clr = 0;
    wait_n(3);
    chk("R9 alive in reset", alive, 0);
    chk("R1 permit in reset", permit, 0);
    chk("R7 fault in reset", fault, 0);
    chk("R8 link in reset", link, 0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R9 alive before third edge", alive, 0);
    wait_n(1);
    chk("R9 alive after third edge", alive, 1);
    wait_n(4);
  endtask

  task automatic t_ready_high();
    bit g;
    chk("R1 permit idle ready", permit, 1);
    for (int k = 0; k < 4; k++) begin
      start_byte(g);
      chk("R1 grant with ready", g, 1);
      chk("R8 link while in flight", link, 1);
      chk("R1 no permit while in flight", permit, 0);
      end_byte();
      chk("R8 link idle", link, 0);
    end
  endtask

  task automatic t_overrun();
    bit g;
    ready = 0;
    wait_n(3);
    start_byte(g); end_byte(); chk("R2 first extra byte", g, 1);
    start_byte(g); end_byte(); chk("R2 second extra byte", g, 1);
    chk("R2 allowance spent", permit, 0);
    start_byte(g); chk("R2 third byte refused", g, 0);
    chk("R2 refused byte not in flight", link, 0);
    ready = 1;
    wait_n(3);
    chk("R3 permit after ready returns", permit, 1);
    ready = 0;
    wait_n(3);
    start_byte(g); end_byte(); chk("R3 reload first", g, 1);
    start_byte(g); end_byte(); chk("R3 reload second", g, 1);
    chk("R3 spent again", permit, 0);
    ready = 1;
    wait_n(3);
  endtask

  task automatic t_equip();
    bit g;
    ok = 0;
    wait_n(4);
    chk("R6 ok low while idle ignored", fault, 0);
    ok = 1;
    wait_n(3);
    start_byte(g);
    ok = 0;
    wait_n(2);
    chk("R10 fault not yet", fault, 0);
    wait_n(1);
    chk("R10 fault at third edge", fault, 1);
    chk("R4 cause equip", cause, 1);
    chk("R7 fault blocks permit", permit, 0);
    do_clear();
    chk("R7 clear loses to nothing", fault, 0);
    wait_n(1);
    chk("R7 re-latch while condition persists", fault, 1);
    ok = 1;
    end_byte();
    wait_n(3);
    chk("R7 fault held until clear", cause, 1);
    do_clear();
    chk("R7 cleared", fault, 0);
    chk("R7 cause none", cause, 0);
    chk("R7 permit back", permit, 1);
    cfg_ok_chk = 0;
    start_byte(g);
    ok = 0;
    wait_n(4);
    chk("R4 check disabled", fault, 0);
    end_byte();
    ok = 1; cfg_ok_chk = 1;
    wait_n(3);
  endtask

  task automatic t_paper();
    bit g;
    start_byte(g);
    paper = 1;
    wait_n(4);
    chk("R5 high paper error", cause, 2);
    end_byte(); paper = 0; wait_n(3); do_clear();
    cfg_pap_hi = 0;
    paper = 1;
    wait_n(3);
    start_byte(g);
    wait_n(3);
    chk("R5 high paper fine when bit 0", fault, 0);
    paper = 0;
    wait_n(4);
    chk("R5 low paper error when bit 0", cause, 2);
    end_byte(); paper = 1; wait_n(3); do_clear();
    cfg_pap_hi = 1; paper = 0;
    wait_n(3);
    start_byte(g);
    paper = 1; ok = 0;
    wait_n(4);
    chk("R6 equip wins over paper", cause, 1);
    end_byte(); paper = 0; ok = 1; wait_n(3); do_clear();
  endtask

  task automatic t_link();
    cfg_link_all = 1;
    wait_n(1);
    chk("R8 link forced while idle", link, 1);
    cfg_link_all = 0;
    wait_n(1);
    chk("R8 link follows flight", link, 0);
  endtask

  initial begin
    t_reset();
    t_ready_high();
    t_overrun();
    t_equip();
    t_paper();
    t_link();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (completion)");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule